// File: doc/BRIEF.md
# Four-Bit Sliced ALU with Rippled Magnitude Compare

This block is a small combinational arithmetic and logic unit. It is built from a row of identical one-bit slices. A three-bit select code picks one of eight operations on the operands A and B: two additions, three bitwise logic operations and three pass-through operations. The word result is driven together with a carry-out.

Each slice also carries a greater-than / less-than flag pair. These flags ripple from the least significant slice to the most significant one. The top slice therefore reports the unsigned magnitude relation of the whole words. The compare path shares no gates with the arithmetic path, so the flags are valid whatever operation is selected.

The carry input is active-high. A carry-in of one adds one. Together with the inverted-B addition, this gives true subtraction.

Top module: `bsalu_word`

## Requirements
- R1: The select code chooses the operation as follows: 0 = A+B, 1 = A+~B, 2 = A|B, 3 = A&B, 4 = A^B, 5 = B, 6 = ~B, 7 = A. All operands and the result are 4 bits wide.
- R2: With code 0, the result is the low 4 bits of A+B+carry-in, and carry-out is bit 4 of that sum.
- R3: With code 1, the result is the low 4 bits of A+(~B)+carry-in, and carry-out is bit 4 of that sum. With carry-in 1, the result is A-B modulo 16 and carry-out is 1 exactly when A>=B. With carry-in 0, the result is A-B-1 modulo 16.
- R4: Codes 2, 3 and 4 give the bitwise OR, AND and XOR of A and B.
- R5: Codes 5, 6 and 7 give B, the bitwise inverse of B, and A.
- R6: Carry-out is 0 for every code from 2 to 7, whatever the carry-in.
- R7: The greater flag is 1 exactly when A>B unsigned, and the less flag is 1 exactly when A<B unsigned. The two flags are never both 1, and both are 0 when A equals B.
- R8: The compare flags depend only on A and B. They are unaffected by the select code and the carry-in.
- R9: The block holds no state. Every output follows its inputs within the same clock period of the surrounding logic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| carry_i | input | 1 | Active-high carry into the least significant slice |
| sel_i | input | 3 | Operation select code |
| result_o | output | 4 | Operation result |
| carry_o | output | 1 | Carry out of the most significant slice (0 for non-arithmetic codes) |
| a_gt_b_o | output | 1 | A greater than B, unsigned |
| a_lt_b_o | output | 1 | A less than B, unsigned |

## Verification
Every output is due zero cycles after its stimulus, because no register lies between any input and any output. The bench drives a new vector just after a rising edge and compares all four outputs at the following falling edge. This gives the carry and compare ripples half a period to settle, and keeps both drive and compare away from the edge. The sweep covers every combination of A, B, carry-in and select code, so each flag result is also checked under all eight codes and both carry values.

// File: rtl/bsalu_pkg.sv
// Package: shared operation encoding for the sliced ALU.
// Assumes: a 3-bit select code; the code order is part of the block's interface.
package bsalu_pkg;
    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_ADDNB = 3'd1,
        OP_OR    = 3'd2,
        OP_AND   = 3'd3,
        OP_XOR   = 3'd4,
        OP_PASSB = 3'd5,
        OP_NOTB  = 3'd6,
        OP_PASSA = 3'd7
    } op_e;
endpackage

// File: rtl/bsalu_cmp_cell.sv
// Module: one stage of the magnitude compare ripple.
// A stage whose bits differ decides the flags itself.
// A stage whose bits match forwards the flags it receives.
// Assumes: the incoming flags are never both set.
module bsalu_cmp_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic gt_i,
    input  logic lt_i,
    output logic gt_o,
    output logic lt_o
);
    logic same;

    // Bits equal: no decision at this stage.
    assign same = ~(a_i ^ b_i);

    // Mirror-image flag equations.
    always_comb begin
        gt_o = (a_i & ~b_i) | (same & gt_i);
        lt_o = (~a_i & b_i) | (same & lt_i);
    end

    // R7: an exclusive input pair must stay exclusive.
    always_comb begin
        if (!(gt_i && lt_i))
            p_flags_exclusive_r7: assert (!(gt_o && lt_o))
                else $error("compare stage drove both flags");
    end
endmodule

// File: rtl/bsalu_bit_slice.sv
// Module: one-bit ALU slice.
// Computes the selected operation on one bit pair, with an active-high carry.
// Carry-out is forced to zero outside the two add codes.
// Contains its own compare stage, which is independent of the operation.
module bsalu_bit_slice
    import bsalu_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    input  logic carry_i,
    input  op_e  op_i,
    input  logic gt_i,
    input  logic lt_i,
    output logic res_o,
    output logic carry_o,
    output logic gt_o,
    output logic lt_o
);
    logic b_eff;
    logic half;

    // B seen by the adder: inverted for the subtract-style add.
    assign b_eff = (op_i == OP_ADDNB) ? ~b_i : b_i;
    assign half  = a_i ^ b_eff;

    // Result and carry for the selected operation.
    always_comb begin
        carry_o = 1'b0;
        case (op_i)
            OP_ADD, OP_ADDNB: begin
                res_o   = half ^ carry_i;
                carry_o = (a_i & b_eff) | (carry_i & half);
            end
            OP_OR:    res_o = a_i | b_i;
            OP_AND:   res_o = a_i & b_i;
            OP_XOR:   res_o = a_i ^ b_i;
            OP_PASSB: res_o = b_i;
            OP_NOTB:  res_o = ~b_i;
            OP_PASSA: res_o = a_i;
            default:  res_o = 1'b0;
        endcase
    end

    bsalu_cmp_cell u_cmp (
        .a_i  (a_i),
        .b_i  (b_i),
        .gt_i (gt_i),
        .lt_i (lt_i),
        .gt_o (gt_o),
        .lt_o (lt_o)
    );
endmodule

// File: rtl/bsalu_word.sv
// Module: ALU word built from a chain of identical one-bit slices.
// Carry ripples from the LSB to the MSB, and so do the compare flags,
// whose entry point is tied low.
// Purely combinational, so there is no clock and no reset.
module bsalu_word
    import bsalu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_i,
    input  logic [2:0]       sel_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             a_gt_b_o,
    output logic             a_lt_b_o
);
    localparam int NLINK = WIDTH + 1;

    op_e              op;
    logic [NLINK-1:0] cy;
    logic [NLINK-1:0] gt;
    logic [NLINK-1:0] lt;

    // Decode the select code and seed the ripple chains.
    assign op    = op_e'(sel_i);
    assign cy[0] = carry_i;
    assign gt[0] = 1'b0;
    assign lt[0] = 1'b0;

    // One slice per bit, each chained to its lower neighbour.
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        bsalu_bit_slice u_slice (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .carry_i (cy[i]),
            .op_i    (op),
            .gt_i    (gt[i]),
            .lt_i    (lt[i]),
            .res_o   (result_o[i]),
            .carry_o (cy[i+1]),
            .gt_o    (gt[i+1]),
            .lt_o    (lt[i+1])
        );
    end

    // Word outputs come from the most significant link.
    assign carry_o  = cy[WIDTH];
    assign a_gt_b_o = gt[WIDTH];
    assign a_lt_b_o = lt[WIDTH];

    // Port-level checks on the rippled results.
    always_comb begin
        if (a_i == b_i)
            p_equal_no_flag_r7: assert (!a_gt_b_o && !a_lt_b_o)
                else $error("flag set on equal operands");
        if (sel_i >= 3'd2)
            p_carry_idle_r6: assert (!carry_o)
                else $error("carry out on non-arithmetic code");
        if (sel_i == 3'd7)
            p_pass_a_r5: assert (result_o == a_i)
                else $error("pass-A result mismatch");
        if (sel_i == 3'd1 && carry_i)
            p_sub_no_borrow_r3: assert (carry_o == (a_i >= b_i))
                else $error("subtract carry mismatch");
    end
endmodule

// File: tb/bsalu_word_bench.sv
// Bench: exhaustive sweep of all operands, carry-in values and select codes.
// Expected values are computed arithmetically from the requirements.
module bsalu_word_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] a, b, res;
    logic       cin, cout, gt, lt;
    logic [2:0] sel;
    int         n_vec  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;

    // 125 MHz clock.
    always #4 clk = ~clk;

    bsalu_word u_bsalu_word (
        .a_i      (a),
        .b_i      (b),
        .carry_i  (cin),
        .sel_i    (sel),
        .result_o (res),
        .carry_o  (cout),
        .a_gt_b_o (gt),
        .a_lt_b_o (lt)
    );

    // Compare one field and report a miscompare.
    task automatic chk(input string tag, input int act, input int exp);
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d cin=%0d sel=%0d: got %0d expected %0d",
                     tag, a, b, cin, sel, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int exp_res, exp_cy, full;
        rst_n = 1'b0;
        a = '0; b = '0; cin = 1'b0; sel = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Quiet state, all inputs zero: result 0, no carry, no flags (R2, R7).
        n_vec++;
        chk("R2 quiet result", res, 0);
        chk("R2 quiet carry", cout, 0);
        chk("R7 quiet gt", gt, 0);
        chk("R7 quiet lt", lt, 0);
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 2; c++) begin
                for (int ia = 0; ia < 16; ia++) begin
                    for (int ib = 0; ib < 16; ib++) begin
                        @(posedge clk);
                        a = 4'(ia); b = 4'(ib); cin = 1'(c); sel = 3'(s);
                        exp_cy = 0;
                        case (s)
                            0: begin full = ia + ib + c; exp_res = full % 16; exp_cy = full / 16; end
                            1: begin full = ia + (15 - ib) + c; exp_res = full % 16; exp_cy = full / 16; end
                            2: exp_res = ia | ib;
                            3: exp_res = ia & ib;
                            4: exp_res = ia ^ ib;
                            5: exp_res = ib;
                            6: exp_res = 15 - ib;
                            default: exp_res = ia;
                        endcase
                        @(negedge clk);
                        n_vec++;
                        // Same-cycle response to new inputs (R9).
                        if (s == 0)      chk("R2 sum", res, exp_res);
                        else if (s == 1) chk("R3 sub-add", res, exp_res);
                        else if (s < 5)  chk("R4 logic", res, exp_res);
                        else             chk("R5 pass", res, exp_res);
                        if (s == 1 && c == 1) begin
                            chk("R3 true difference", res, (ia - ib + 16) % 16);
                            chk("R3 no-borrow carry", cout, (ia >= ib) ? 1 : 0);
                        end
                        if (s < 2) chk("R1 arith carry", cout, exp_cy);
                        else       chk("R6 carry forced low", cout, 0);
                        // Flags are checked under every code and carry-in value (R8).
                        chk("R7 R8 gt flag", gt, (ia > ib) ? 1 : 0);
                        chk("R7 R8 lt flag", lt, (ia < ib) ? 1 : 0);
                    end
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule